// File: doc/BRIEF.md
# Pipelined FIR convolver with three-operand adder tree

This block convolves a stream of real, signed two's-complement samples with a fixed set of signed coefficients. Each accepted sample is combined with the previous `NUM_TAPS-1` accepted samples, which are held in a history register chain. Every one of these `NUM_TAPS` values is multiplied by its own coefficient at full precision. The products are then summed by a registered reduction tree built only from three-input adders. At each tree level the operand count is rounded up to a multiple of three with zero operands, and each level widens its results by two bits, so no sum can overflow.

The coefficient set is a parameter fixed at build time. Complex streams are handled by placing one instance on the in-phase part and another on the quadrature part. A sample is taken when `in_valid` is high. Exactly one result, flagged by `out_valid`, follows each taken sample after a fixed number of clock edges. A synchronous `clear` empties the history and discards every result still in flight.

Top module: `tdl_add3_fir`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_result` are 0 and the sample history is zero. After reset is released, the first result therefore depends only on the first accepted sample.
- R2: A sample is accepted at a rising edge where `in_valid` is 1 and `clear` is 0. Tap 0 is the newest accepted sample, and tap i is the sample accepted i acceptances earlier. Edges with `in_valid` 0 leave the history unchanged, so idle gaps do not alter later results.
- R3: `out_result` is the signed sum over taps i of `COEFS[i*COEF_W +: COEF_W]` (signed) times tap i. It is computed exactly in `OUT_W = SAMPLE_W + COEF_W + 2*LEVELS` bits, two's complement, with no overflow even when every tap holds the most negative or the most positive sample.
- R4: Each accepted sample gives exactly one `out_valid` pulse, 1+LEVELS rising edges after acceptance, counting the accepting edge as the first. Results keep their input order. LEVELS is the number of steps n -> ceil(n/3) needed to go from NUM_TAPS down to 1, which is 2 for the default of 8 taps.
- R5: A sample of value 1 followed by NUM_TAPS-1 samples of value 0 gives the results COEFS for tap 0, 1, ... NUM_TAPS-1, in that order. One further 0 sample then gives 0.
- R6: A rising edge with `clear` high zeroes the history and every pipeline register. No result is produced for any sample accepted before that edge but not yet output, and a sample offered with `in_valid` high in the same cycle is ignored.
- R7: `out_result` keeps its value while `out_valid` is low. The only exception is the edge after a clear, which sets it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of history and pipeline |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SAMPLE_W | Signed input sample |
| out_valid | output | 1 | Result strobe |
| out_result | output | OUT_W | Signed convolution result |

## Verification
A wrong history entry shows up as a wrong result within 1+LEVELS edges of the next accepted sample. It stays visible for up to NUM_TAPS results, because every later output that still covers that tap is affected. The impulse test exposes a swapped, misindexed or wrongly sign-extended coefficient on the first few outputs. Long runs at full-scale values expose a missing guard bit or a bad zero pad in the tree. A pipeline valid flag that is dropped, duplicated or not cleared appears at once as a missing, extra or mistimed `out_valid` pulse against the scoreboard's due cycle.

// File: rtl/tdl3_pkg.sv
package tdl3_pkg;

    // ceil(n/3): number of three-input adders that a level of n operands needs
    function automatic int div3_ceil(input int n);
        return (n + 2) / 3;
    endfunction

    // number of adder levels needed to reduce n operands to one
    function automatic int tree_levels(input int n);
        int c;
        int l;
        c = n;
        l = 0;
        while (c > 1) begin
            c = div3_ceil(c);
            l++;
        end
        return l;
    endfunction

    // operand count entering adder level lvl
    function automatic int level_count(input int n, input int lvl);
        int c;
        c = n;
        for (int i = 0; i < lvl; i++) c = div3_ceil(c);
        return c;
    endfunction

endpackage

// File: rtl/tdl3_tap_chain.sv
module tdl3_tap_chain #(
    parameter int SAMPLE_W = 17,
    parameter int NUM_TAPS = 8,
    localparam int HIST    = NUM_TAPS - 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       shift_en,
    input  logic [SAMPLE_W-1:0]        sample_in,
    output logic [HIST*SAMPLE_W-1:0]   hist_flat
);

    typedef struct packed {
        logic [HIST-1:0][SAMPLE_W-1:0] hist;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (shift_en) begin
            for (int i = HIST - 1; i > 0; i--) begin
                st_d.hist[i] = st_q.hist[i-1];
            end
            st_d.hist[0] = sample_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hist_flat = st_q.hist;

endmodule

// File: rtl/tdl3_mult_bank.sv
module tdl3_mult_bank #(
    parameter int SAMPLE_W = 17,
    parameter int NUM_TAPS = 8,
    parameter int COEF_W   = 12,
    parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = '0,
    localparam int HIST    = NUM_TAPS - 1,
    localparam int PROD_W  = SAMPLE_W + COEF_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          accept,
    input  logic [SAMPLE_W-1:0]           in_sample,
    input  logic [HIST*SAMPLE_W-1:0]      hist_flat,
    output logic                          prod_vld,
    output logic [NUM_TAPS*PROD_W-1:0]    prod_flat
);

    typedef struct packed {
        logic                              vld;
        logic [NUM_TAPS-1:0][PROD_W-1:0]   prods;
    } mult_t;

    mult_t st_d, st_q;

    // window of taps seen by the sample being accepted: new sample at tap 0
    logic [NUM_TAPS-1:0][SAMPLE_W-1:0] window;
    logic [NUM_TAPS-1:0][PROD_W-1:0]   prod_w;

    assign window[0] = in_sample;

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        logic signed [SAMPLE_W-1:0] smp;
        logic signed [COEF_W-1:0]   cof;
        if (t > 0) begin : g_old
            assign window[t] = hist_flat[(t-1)*SAMPLE_W +: SAMPLE_W];
        end
        assign smp       = window[t];
        assign cof       = COEFS[t*COEF_W +: COEF_W];
        assign prod_w[t] = PROD_W'(smp) * PROD_W'(cof);
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (clear) begin
            st_d = '0;
        end else if (accept) begin
            st_d.vld   = 1'b1;
            st_d.prods = prod_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prod_vld  = st_q.vld;
    assign prod_flat = st_q.prods;

endmodule

// File: rtl/tdl3_add3_level.sv
module tdl3_add3_level
    import tdl3_pkg::*;
#(
    parameter int IN_CNT  = 8,
    parameter int IN_W    = 29,
    localparam int OUT_CNT = div3_ceil(IN_CNT),
    localparam int PAD_CNT = 3 * OUT_CNT,
    localparam int OUT_W   = IN_W + 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        in_vld,
    input  logic [IN_CNT*IN_W-1:0]      in_flat,
    output logic                        out_vld,
    output logic [OUT_CNT*OUT_W-1:0]    out_flat
);

    typedef struct packed {
        logic                              vld;
        logic [OUT_CNT-1:0][OUT_W-1:0]     sums;
    } level_t;

    level_t st_d, st_q;

    // operands sign-extended by two guard bits, zero beyond IN_CNT
    logic [PAD_CNT-1:0][OUT_W-1:0] opnd;

    for (genvar k = 0; k < PAD_CNT; k++) begin : g_pad
        if (k < IN_CNT) begin : g_live
            logic [IN_W-1:0] raw;
            assign raw     = in_flat[k*IN_W +: IN_W];
            assign opnd[k] = {{2{raw[IN_W-1]}}, raw};
        end else begin : g_zero
            assign opnd[k] = '0;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (clear) begin
            st_d = '0;
        end else if (in_vld) begin
            st_d.vld = 1'b1;
            for (int j = 0; j < OUT_CNT; j++) begin
                st_d.sums[j] = opnd[3*j] + opnd[3*j+1] + opnd[3*j+2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign out_flat = st_q.sums;

endmodule

// File: rtl/tdl_add3_fir.sv
module tdl_add3_fir
    import tdl3_pkg::*;
#(
    parameter int SAMPLE_W = 17,
    parameter int NUM_TAPS = 8,
    parameter int COEF_W   = 12,
    // tap i coefficient sits at bits [i*COEF_W +: COEF_W]
    parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = {
        12'h005, 12'hFFF, 12'h064, 12'h800,
        12'h7FF, 12'h040, 12'hFEF, 12'h003},
    localparam int LEVELS  = tree_levels(NUM_TAPS),
    localparam int PROD_W  = SAMPLE_W + COEF_W,
    localparam int OUT_W   = PROD_W + 2 * LEVELS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 in_valid,
    input  logic [SAMPLE_W-1:0]  in_sample,
    output logic                 out_valid,
    output logic [OUT_W-1:0]     out_result
);

    localparam int HIST = NUM_TAPS - 1;
    localparam int LAT  = 1 + LEVELS;

    logic                          accept;
    logic [HIST*SAMPLE_W-1:0]      hist_flat;
    logic                          prod_vld;
    logic [NUM_TAPS*PROD_W-1:0]    prod_flat;

    assign accept = in_valid && !clear;

    tdl3_tap_chain #(
        .SAMPLE_W (SAMPLE_W),
        .NUM_TAPS (NUM_TAPS)
    ) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .shift_en  (accept),
        .sample_in (in_sample),
        .hist_flat (hist_flat)
    );

    tdl3_mult_bank #(
        .SAMPLE_W (SAMPLE_W),
        .NUM_TAPS (NUM_TAPS),
        .COEF_W   (COEF_W),
        .COEFS    (COEFS)
    ) u_mult (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .accept    (accept),
        .in_sample (in_sample),
        .hist_flat (hist_flat),
        .prod_vld  (prod_vld),
        .prod_flat (prod_flat)
    );

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int IN_CNT = level_count(NUM_TAPS, l);
        localparam int IN_W   = PROD_W + 2 * l;
        localparam int O_CNT  = div3_ceil(IN_CNT);
        localparam int O_W    = IN_W + 2;

        logic [IN_CNT*IN_W-1:0] stage_in;
        logic                   stage_in_vld;
        logic [O_CNT*O_W-1:0]   stage_out;
        logic                   stage_out_vld;

        if (l == 0) begin : g_first
            assign stage_in     = prod_flat;
            assign stage_in_vld = prod_vld;
        end else begin : g_next
            assign stage_in     = g_lvl[l-1].stage_out;
            assign stage_in_vld = g_lvl[l-1].stage_out_vld;
        end

        tdl3_add3_level #(
            .IN_CNT (IN_CNT),
            .IN_W   (IN_W)
        ) u_level (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clear),
            .in_vld   (stage_in_vld),
            .in_flat  (stage_in),
            .out_vld  (stage_out_vld),
            .out_flat (stage_out)
        );
    end

    assign out_valid  = g_lvl[LEVELS-1].stage_out_vld;
    assign out_result = g_lvl[LEVELS-1].stage_out;

endmodule

// File: rtl/tdl3_fir_chk.sv
module tdl3_fir_chk #(
    parameter int SAMPLE_W = 17,
    parameter int NUM_TAPS = 8,
    parameter int OUT_W    = 33,
    parameter int LAT      = 3
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            clear,
    input logic                            in_valid,
    input logic [SAMPLE_W-1:0]             in_sample,
    input logic [(NUM_TAPS-1)*SAMPLE_W-1:0] hist_flat,
    input logic                            out_valid,
    input logic [OUT_W-1:0]                out_result
);

    // independent record of which edges accepted a sample
    logic [LAT-1:0] taken_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     taken_q <= '0;
        else if (clear) taken_q <= '0;
        else            taken_q <= {taken_q[LAT-2:0], in_valid};
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == taken_q[LAT-1]); // R4

    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!out_valid && out_result == '0)); // R6

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !$past(clear)) |-> $stable(out_result)); // R7

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !in_valid) |=> $stable(hist_flat)); // R2

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && in_valid) |=> hist_flat[SAMPLE_W-1:0] == $past(in_sample)); // R2

endmodule

bind tdl_add3_fir tdl3_fir_chk #(
    .SAMPLE_W (SAMPLE_W),
    .NUM_TAPS (NUM_TAPS),
    .OUT_W    (OUT_W),
    .LAT      (LAT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .hist_flat  (hist_flat),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/test_tdl_add3_fir.sv
`timescale 1ns/1ps
module test_tdl_add3_fir;

    localparam int S_W    = 17;
    localparam int TAPS   = 8;
    localparam int C_W    = 12;
    localparam int LVL_TB = 2;              // 8 -> 3 -> 1
    localparam int O_W    = S_W + C_W + 2 * LVL_TB;
    localparam int CF [TAPS] = '{3, -17, 64, 2047, -2048, 100, -1, 5};

    function automatic logic [TAPS*C_W-1:0] pack_coefs();
        logic [TAPS*C_W-1:0] v;
        v = '0;
        for (int i = 0; i < TAPS; i++) v[i*C_W +: C_W] = C_W'(CF[i]);
        return v;
    endfunction

    localparam logic [TAPS*C_W-1:0] TB_COEFS = pack_coefs();

    logic clk = 1'b0;
    logic rst_n, clear, in_valid;
    logic [S_W-1:0] in_sample;
    logic out_valid;
    logic [O_W-1:0] out_result;

    always #4 clk = ~clk;

    tdl_add3_fir #(
        .SAMPLE_W (S_W),
        .NUM_TAPS (TAPS),
        .COEF_W   (C_W),
        .COEFS    (TB_COEFS)
    ) i_tdl_add3_fir (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    typedef struct {
        longint val;
        int     due;
        string  req;
    } item_t;

    item_t  sb_q[$];
    longint hist[TAPS];
    longint last_seen = 0;
    int     cyc = 0;
    int     checks = 0;
    int     fails = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // driver: called at negedge+1; sample taken at the next rising edge
    task automatic send(input longint s, input string req);
        item_t it;
        longint acc;
        in_valid  = 1'b1;
        in_sample = S_W'(s);
        for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = s;
        acc = 0;
        for (int i = 0; i < TAPS; i++) acc += longint'(CF[i]) * hist[i];
        it.val = acc;
        it.due = cyc + 1 + LVL_TB;
        it.req = req;
        sb_q.push_back(it);
        @(negedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic do_clear(input bit with_sample);
        clear = 1'b1;
        in_valid  = with_sample;
        in_sample = S_W'(12345);
        sb_q.delete();
        for (int i = 0; i < TAPS; i++) hist[i] = 0;
        @(negedge clk); #1;
        clear = 1'b0;
        in_valid = 1'b0;
        last_seen = 0;
    endtask

    // monitor: compares results as they appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R4/R6 unexpected out_valid", longint'($signed(out_result)), 0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(longint'($signed(out_result)) == it.val, it.req,
                          longint'($signed(out_result)), it.val);
                    check(cyc == it.due, "R4 latency", cyc, it.due);
                    last_seen = longint'($signed(out_result));
                end
            end else if (sb_q.size() != 0 && sb_q[0].due <= cyc) begin
                check(1'b0, "R4 missing result", 0, sb_q[0].val);
                void'(sb_q.pop_front());
            end
        end
    end

    task automatic drain();
        int guard;
        guard = 0;
        while (sb_q.size() != 0 && guard < 50) begin
            @(negedge clk); #1;
            guard++;
        end
        idle(2);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; clear = 1'b0; in_valid = 1'b0; in_sample = '0;
        for (int i = 0; i < TAPS; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        check(out_result == '0, "R1 out_result in reset", longint'($signed(out_result)), 0);
        #1; rst_n = 1'b1;
        idle(2);

        // R5 / R1: impulse right after reset reproduces the coefficient list
        send(1, "R5 impulse tap0 (R1 clean history)");
        for (int i = 1; i < TAPS; i++) send(0, $sformatf("R5 impulse tap%0d", i));
        send(0, "R5 impulse tail zero");
        drain();

        // R7: result holds while out_valid is low
        for (int i = 0; i < 4; i++) begin
            check(!out_valid && longint'($signed(out_result)) == last_seen,
                  "R7 hold while idle", longint'($signed(out_result)), last_seen);
            idle(1);
        end

        // R2: samples with idle gaps between them
        for (int i = 0; i < 20; i++) begin
            send(longint'($urandom_range(0, 2000)) - 1000, "R2 gapped stream");
            idle($urandom_range(0, 3));
        end
        drain();

        // R3: full-scale extremes
        for (int i = 0; i < TAPS; i++) send(-65536, "R3 most negative");
        for (int i = 0; i < TAPS; i++) send(65535, "R3 most positive");
        for (int i = 0; i < TAPS; i++) send((i % 2) ? -65536 : 65535, "R3 alternating");
        drain();

        // R6: clear with results in flight and a sample offered together with clear
        send(500, "R6 before clear");
        send(-700, "R6 before clear");
        send(900, "R6 before clear");
        do_clear(1'b1);
        for (int i = 0; i < 4; i++) begin
            check(!out_valid, "R6 no output after clear", out_valid, 0);
            check(out_result == '0, "R6 result zero after clear", longint'($signed(out_result)), 0);
            idle(1);
        end
        send(1, "R6 history empty after clear");
        send(0, "R6 history empty after clear");
        drain();

        // R3 / R4: long random back-to-back and gapped traffic
        for (int i = 0; i < 300; i++) begin
            send(longint'($urandom_range(0, 131071)) - 65536, "R3 random stream");
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        drain();

        finish_run();
    end

endmodule